// File: doc/BRIEF.md
# DS3 Transmit Payload Input Interface

This block sits in front of a DS3 transmit framer. It accepts payload data from the user side and places that data in the correct slots of the outgoing frame. Data arrives on one of two paths: a single serial bit per bit period, or a four-bit nibble every four bit periods. The framer receives three things from the block: a frame-start indication, a payload-slot indication, and the captured payload with a one-cycle valid pulse.

All timing comes from strobes on a single system clock. One strobe marks a rising edge of the recovered receive clock, and the other marks a rising edge of the local transmit clock. Under loop timing, the recovered strobe paces the transmit bit periods. Under local timing, the local strobe paces them.

Under local timing the block runs in one of two ways. As frame master, it free-runs its frame counter. As frame slave, a rising edge on an external reference input restarts the frame. A reference edge that arrives in the middle of a frame sets a sticky misalignment flag. Mode selections are held until the next frame boundary.

Top module: `ds3_tx_payload_if`

## Requirements
- R1: `tx_bit_ce` equals `rec_ce` when the active mode is loop timing, and equals `loc_ce` when it is local timing. The unselected strobe has no effect on the frame position.
- R2: The frame is SUBS x BLKS x (PAY_BITS+1) bit periods long. Reset places the position at bit 0. The position advances by one on each `tx_bit_ce` and wraps to 0. `frm_start` is 1 exactly while the position is bit 0.
- R3: Each frame is a series of blocks of PAY_BITS+1 bits, and offset 0 of each block is an overhead bit. `pay_slot` is 0 at overhead positions and 1 at all other positions.
- R4: In serial mode (`cfg_nibble`=0), a `tx_bit_ce` during a payload slot produces `cap_vld`=1 in the next cycle, with `cap_data` = {3'b000, `ser_in`}. No capture happens at overhead positions.
- R5: In nibble mode (`cfg_nibble`=1), `nib_req` is 1 only at positions that are a multiple of 4 and whose four positions p..p+3 are all payload. A `tx_bit_ce` while `nib_req` is 1 captures `nib_in` into `cap_data`, with `cap_valid` following in the next cycle. Bit 3 of `nib_in` is the earliest-sent bit.
- R6: The mode inputs (`cfg_nibble`, `cfg_loop`, `cfg_master`) are loaded while reset is held. After reset they are loaded only on a bit strobe that moves the position to bit 0.
- R7: Frame slave mode is local timing with `cfg_master`=0. In that mode, a rising edge of `frm_ref`, sampled on `loc_ce`, makes that bit strobe move the position to bit 0.
- R8: Under loop timing, or in master mode, `frm_ref` has no effect on the frame position.
- R9: `misalign` is set when a slave restart occurs at any position other than the last bit of the frame, and it stays set. `mis_clr` clears it. If a set and a clear occur in the same cycle, the set wins.
- R10: `rec_clk_o` toggles on every `rec_ce` in every mode and is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rec_ce | input | 1 | Rising-edge strobe of the recovered receive clock |
| loc_ce | input | 1 | Rising-edge strobe of the local transmit clock |
| cfg_nibble | input | 1 | 1 selects the nibble path, 0 the serial path |
| cfg_loop | input | 1 | 1 selects loop timing, 0 local timing |
| cfg_master | input | 1 | 1 selects frame master, 0 frame slave (local timing only) |
| frm_ref | input | 1 | Frame reference, synchronous to the local clock |
| mis_clr | input | 1 | Clears the misalignment flag |
| ser_in | input | 1 | Serial payload bit |
| nib_in | input | 4 | Payload nibble, bit 3 sent first |
| tx_bit_ce | output | 1 | Selected transmit bit-period strobe |
| frm_start | output | 1 | High during bit 0 of the frame |
| pay_slot | output | 1 | High during payload bit positions |
| nib_req | output | 1 | Nibble wanted on the next bit strobe |
| cap_vld | output | 1 | One-cycle pulse: `cap_data` updated |
| cap_data | output | 4 | Captured payload (serial bit in bit 0) |
| misalign | output | 1 | Sticky flag for a mid-frame slave restart |
| rec_clk_o | output | 1 | Recovered clock image, toggles per `rec_ce` |

## Verification
The hardest situation to reach from the ports is a slave restart that lands on one exact frame position while a mode change is pending. The misalignment clear must also land in the same cycle as a new set. The bench reaches these states by tracking the frame position in its own model. It steps random strobes until the model shows the wanted position. It then forces a local strobe with the reference raised, and also raises the clear when the set/clear collision is the target. The bench uses a 40-bit frame, which lets it sweep every position many times under random strobe patterns and in every mode.

// File: rtl/ds3_txpi_pkg.sv
// Shared types for the DS3 transmit payload input interface.
package ds3_txpi_pkg;

    // Active operating mode: data path, timing source, frame alignment role.
    typedef struct packed {
        logic nibble;  // 1: four-bit path, 0: serial path
        logic loop;    // 1: recovered clock paces transmit
        logic master;  // 1: free-running frame (local timing only)
    } txpi_mode_t;

    // A reference edge only matters for a local-timing frame slave.
    function automatic logic ref_honoured(txpi_mode_t m);
        return !m.loop && !m.master;
    endfunction

endpackage

// File: rtl/txpi_clk_sel.sv
// Timing selection: picks the bit strobe for the active timing source,
// detects frame-reference rising edges in the local clock domain, and
// keeps an image of the recovered clock running in all modes.
// Assumes frm_ref is already synchronous to the local transmit clock,
// so it is edge-detected without a resynchronizer.
module txpi_clk_sel
    import ds3_txpi_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rec_ce,
    input  logic       loc_ce,
    input  logic       frm_ref,
    input  txpi_mode_t act_mode,
    output logic       bit_ce,
    output logic       ref_restart,
    output logic       rec_clk_o
);

    logic ref_q;

    // Bit strobe follows the timing source of the active mode.
    always_comb bit_ce = act_mode.loop ? rec_ce : loc_ce;

    // Reference level as seen at the previous local clock edge.
    always_ff @(posedge clk) begin
        if (!rst_n)      ref_q <= 1'b0;
        else if (loc_ce) ref_q <= frm_ref;
    end

    // Restart request: rising reference edge, slave role only.
    always_comb ref_restart = loc_ce & frm_ref & ~ref_q & ref_honoured(act_mode);

    // Recovered clock image toggles on each recovered edge, every mode.
    always_ff @(posedge clk) begin
        if (!rst_n)      rec_clk_o <= 1'b0;
        else if (rec_ce) rec_clk_o <= ~rec_clk_o;
    end

    // R1
    no_strobe_no_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rec_ce && !loc_ce) |-> !bit_ce);

    // R10
    rec_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rec_ce |=> (rec_clk_o != $past(rec_clk_o)));

    // R8
    ref_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act_mode.loop || act_mode.master) |-> !ref_restart);

endmodule

// File: rtl/txpi_frame_ctr.sv
// Frame position counter: tracks block offset, block and subframe within
// the DS3 frame, the nibble phase, and the active mode. It restarts on a
// slave reference edge and flags restarts that cut a frame short.
// Assumes the frame length is a multiple of four and PAY_BITS >= 3.
module txpi_frame_ctr
    import ds3_txpi_pkg::*;
#(
    parameter int PAY_BITS = 84,
    parameter int BLKS     = 8,
    parameter int SUBS     = 7
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bit_ce,
    input  logic       restart,
    input  logic       mis_clr,
    input  txpi_mode_t cfg_mode,
    output txpi_mode_t act_mode,
    output logic       frm_start,
    output logic       pay_slot,
    output logic       nib_ok,
    output logic       misalign
);

    localparam int BLK_LEN = PAY_BITS + 1;
    localparam int OFF_W   = $clog2(BLK_LEN + 1);
    localparam int BLK_W   = $clog2(BLKS + 1);
    localparam int SUB_W   = $clog2(SUBS + 1);
    localparam logic [OFF_W-1:0] LAST_OFF = OFF_W'(BLK_LEN - 1);
    localparam logic [OFF_W-1:0] NIB_LIM  = OFF_W'(BLK_LEN - 4);
    localparam logic [BLK_W-1:0] LAST_BLK = BLK_W'(BLKS - 1);
    localparam logic [SUB_W-1:0] LAST_SUB = SUB_W'(SUBS - 1);

    logic [OFF_W-1:0] blk_off;
    logic [BLK_W-1:0] blk_idx;
    logic [SUB_W-1:0] sub_idx;
    logic [1:0]       ph;
    logic             at_last;
    logic             boundary;

    // Last bit of the frame, and a strobe that moves to bit 0.
    always_comb begin
        at_last  = (blk_off == LAST_OFF) && (blk_idx == LAST_BLK) && (sub_idx == LAST_SUB);
        boundary = bit_ce && (at_last || restart);
    end

    // Position counters: nested offset / block / subframe plus nibble phase.
    always_ff @(posedge clk) begin
        if (!rst_n || boundary) begin
            blk_off <= '0;
            blk_idx <= '0;
            sub_idx <= '0;
            ph      <= '0;
        end else if (bit_ce) begin
            ph <= ph + 2'd1;
            if (blk_off == LAST_OFF) begin
                blk_off <= '0;
                if (blk_idx == LAST_BLK) begin
                    blk_idx <= '0;
                    sub_idx <= (sub_idx == LAST_SUB) ? '0 : sub_idx + 1'b1;
                end else begin
                    blk_idx <= blk_idx + 1'b1;
                end
            end else begin
                blk_off <= blk_off + 1'b1;
            end
        end
    end

    // Mode register: loaded in reset and at each frame boundary.
    always_ff @(posedge clk) begin
        if (!rst_n || boundary) act_mode <= cfg_mode;
    end

    // Sticky misalignment flag; a new set wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                             misalign <= 1'b0;
        else if (bit_ce && restart && !at_last) misalign <= 1'b1;
        else if (mis_clr)                       misalign <= 1'b0;
    end

    // Slot decode from the counter state.
    always_comb begin
        frm_start = (blk_off == '0) && (blk_idx == '0) && (sub_idx == '0);
        pay_slot  = (blk_off != '0);
        nib_ok    = (ph == 2'd0) && (blk_off != '0) && (blk_off <= NIB_LIM);
    end

    // R2
    wrap_to_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_ce && at_last) |=> frm_start);

    // R7
    restart_to_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_ce && restart) |=> frm_start);

    // R9
    misalign_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_ce && restart && !at_last) |=> misalign);

    // R6
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_ce |=> $stable(act_mode));

    // R3
    start_is_ovh_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frm_start |-> !pay_slot);

endmodule

// File: rtl/txpi_capture.sv
// Payload capture: on a bit strobe, takes the serial bit in a payload
// slot or the nibble at a clean four-bit group, and presents it to the
// framer with a one-cycle valid pulse.
// Assumes the slot indications come from the frame counter's present state.
module txpi_capture
    import ds3_txpi_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bit_ce,
    input  txpi_mode_t act_mode,
    input  logic       pay_slot,
    input  logic       nib_ok,
    input  logic       ser_in,
    input  logic [3:0] nib_in,
    output logic       nib_req,
    output logic       cap_vld,
    output logic [3:0] cap_data
);

    logic take;

    // Request and capture qualification for the active data path.
    always_comb begin
        nib_req = act_mode.nibble && nib_ok;
        take    = bit_ce && (act_mode.nibble ? nib_ok : pay_slot);
    end

    // Capture register and valid pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_vld  <= 1'b0;
            cap_data <= '0;
        end else begin
            cap_vld <= take;
            if (take) cap_data <= act_mode.nibble ? nib_in : {3'b000, ser_in};
        end
    end

    // R4
    vld_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap_vld |-> $past(bit_ce));

    // R5
    nib_req_in_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nib_req |-> pay_slot);

endmodule

// File: rtl/ds3_tx_payload_if.sv
// Top of the DS3 transmit payload input interface: strobe selection,
// frame position and payload capture wired together.
// Assumes rec_ce and loc_ce are single-cycle strobes on clk.
module ds3_tx_payload_if
    import ds3_txpi_pkg::*;
#(
    parameter int PAY_BITS = 84,
    parameter int BLKS     = 8,
    parameter int SUBS     = 7
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rec_ce,
    input  logic       loc_ce,
    input  logic       cfg_nibble,
    input  logic       cfg_loop,
    input  logic       cfg_master,
    input  logic       frm_ref,
    input  logic       mis_clr,
    input  logic       ser_in,
    input  logic [3:0] nib_in,
    output logic       tx_bit_ce,
    output logic       frm_start,
    output logic       pay_slot,
    output logic       nib_req,
    output logic       cap_vld,
    output logic [3:0] cap_data,
    output logic       misalign,
    output logic       rec_clk_o
);

    txpi_mode_t cfg_mode;
    txpi_mode_t act_mode;
    logic       ref_restart;
    logic       nib_ok;

    // Gather the mode inputs into one record.
    always_comb cfg_mode = '{nibble: cfg_nibble, loop: cfg_loop, master: cfg_master};

    txpi_clk_sel u_clk (
        .clk        (clk),
        .rst_n      (rst_n),
        .rec_ce     (rec_ce),
        .loc_ce     (loc_ce),
        .frm_ref    (frm_ref),
        .act_mode   (act_mode),
        .bit_ce     (tx_bit_ce),
        .ref_restart(ref_restart),
        .rec_clk_o  (rec_clk_o)
    );

    txpi_frame_ctr #(.PAY_BITS(PAY_BITS), .BLKS(BLKS), .SUBS(SUBS)) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_ce   (tx_bit_ce),
        .restart  (ref_restart),
        .mis_clr  (mis_clr),
        .cfg_mode (cfg_mode),
        .act_mode (act_mode),
        .frm_start(frm_start),
        .pay_slot (pay_slot),
        .nib_ok   (nib_ok),
        .misalign (misalign)
    );

    txpi_capture u_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .bit_ce  (tx_bit_ce),
        .act_mode(act_mode),
        .pay_slot(pay_slot),
        .nib_ok  (nib_ok),
        .ser_in  (ser_in),
        .nib_in  (nib_in),
        .nib_req (nib_req),
        .cap_vld (cap_vld),
        .cap_data(cap_data)
    );

endmodule

// File: tb/sim_ds3_tx_payload_if.sv
// Bench: small frame (2 subframes x 2 blocks x 10 bits = 40), random
// strobes, reference model of the frame position computed arithmetically.
module sim_ds3_tx_payload_if;

    localparam int PB = 9;
    localparam int NB = 2;
    localparam int NS = 2;
    localparam int BL = PB + 1;
    localparam int F  = NS * NB * BL;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rec_ce = 1'b0, loc_ce = 1'b0, frm_ref = 1'b0, mis_clr = 1'b0, ser_in = 1'b0;
    logic [3:0] nib_in = 4'h0;
    logic c_nib = 1'b0, c_loop = 1'b0, c_mst = 1'b1;
    logic tx_bit_ce, frm_start, pay_slot, nib_req, cap_vld, misalign, rec_clk_o;
    logic [3:0] cap_data;

    int total = 0;
    int bad = 0;
    bit done = 0;
    int pos;
    logic m_nib, m_loop, m_mst, m_mis, m_refq, m_rclk;
    logic ref_lvl = 1'b0, clr_lvl = 1'b0;
    logic [15:0] lfsr = 16'hACE1;

    always #5 clk = ~clk;

    ds3_tx_payload_if #(.PAY_BITS(PB), .BLKS(NB), .SUBS(NS)) u0 (
        .clk(clk), .rst_n(rst_n), .rec_ce(rec_ce), .loc_ce(loc_ce),
        .cfg_nibble(c_nib), .cfg_loop(c_loop), .cfg_master(c_mst),
        .frm_ref(frm_ref), .mis_clr(mis_clr), .ser_in(ser_in), .nib_in(nib_in),
        .tx_bit_ce(tx_bit_ce), .frm_start(frm_start), .pay_slot(pay_slot),
        .nib_req(nib_req), .cap_vld(cap_vld), .cap_data(cap_data),
        .misalign(misalign), .rec_clk_o(rec_clk_o)
    );

    task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h (pos %0d)", tag, act, exp, pos);
        end
    endtask

    function automatic bit ovh(input int p);
        return (p % BL) == 0;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; rec_ce = 1'b0; loc_ce = 1'b0; frm_ref = 1'b0; mis_clr = 1'b0;
        ref_lvl = 1'b0; clr_lvl = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        pos = 0; m_nib = c_nib; m_loop = c_loop; m_mst = c_mst;
        m_mis = 1'b0; m_refq = 1'b0; m_rclk = 1'b0;
        #1;
        chk("R2 reset at bit 0", frm_start, 1'b1);
        chk("R9 reset misalign", misalign, 1'b0);
        chk("R4 reset no valid", cap_vld, 1'b0);
        chk("R10 reset clock image", rec_clk_o, 1'b0);
    endtask

    // One system cycle with the given strobes; checks before and after the edge.
    task automatic step(input logic r, input logic l);
        logic ebit, evld, ereq, edg, rst_req;
        logic [3:0] edat;
        @(negedge clk);
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        rec_ce = r; loc_ce = l; ser_in = lfsr[3]; nib_in = lfsr[11:8];
        frm_ref = ref_lvl; mis_clr = clr_lvl;
        #1;
        ebit = m_loop ? r : l;
        ereq = m_nib && (pos % 4 == 0) && !ovh(pos) && !ovh(pos + 1) && !ovh(pos + 2) && !ovh(pos + 3);
        chk("R1 bit strobe", tx_bit_ce, ebit);
        chk("R2 frame start", frm_start, pos == 0);
        chk("R3 payload slot", pay_slot, !ovh(pos));
        chk("R5 nibble request", nib_req, ereq);
        chk("R9 misalign", misalign, m_mis);
        chk("R10 recovered clock image", rec_clk_o, m_rclk);
        evld = ebit && (m_nib ? ereq : !ovh(pos));
        edat = m_nib ? nib_in : {3'b000, ser_in};
        edg = l && ref_lvl && !m_refq;
        rst_req = edg && !m_loop && !m_mst;
        @(posedge clk);
        #1;
        chk(m_nib ? "R5 nibble valid" : "R4 serial valid", cap_vld, evld);
        if (evld) chk(m_nib ? "R5 nibble data" : "R4 serial data", cap_data, edat);
        if (ebit && rst_req && pos != F - 1) m_mis = 1'b1;
        else if (clr_lvl) m_mis = 1'b0;
        if (ebit) begin
            if (rst_req || pos == F - 1) begin
                pos = 0; m_nib = c_nib; m_loop = c_loop; m_mst = c_mst;
            end else begin
                pos++;
            end
        end
        if (l) m_refq = ref_lvl;
        if (r) m_rclk = ~m_rclk;
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) step(lfsr[0], lfsr[5]);
    endtask

    task automatic run_to(input int p);
        while (pos != p) step(lfsr[0], lfsr[5]);
    endtask

    initial begin
        // Serial, local timing, master.
        c_nib = 1'b0; c_loop = 1'b0; c_mst = 1'b1;
        do_reset();
        run(250);
        // R6: nibble request first appears after the boundary.
        run_to(20);
        c_nib = 1'b1;
        step(1'b0, 1'b0);
        chk("R6 mode held mid-frame", nib_req, 1'b0);
        run_to(0);
        run_to(4);
        chk("R6 nibble mode after boundary", nib_req, 1'b1);
        run(250);
        // Nibble, loop timing, master: the local strobe must not advance.
        c_loop = 1'b1;
        run_to(0);
        run(250);
        for (int i = 0; i < 20; i++) step(1'b0, 1'b1);
        // R8: reference ignored under loop timing (slave selection).
        c_mst = 1'b0;
        run_to(0);
        run_to(13);
        ref_lvl = 1'b1; step(1'b1, 1'b1); run(6); ref_lvl = 1'b0; run(6);
        chk("R8 loop ignores reference", misalign, 1'b0);
        // Serial, local, slave.
        c_nib = 1'b0; c_loop = 1'b0;
        run_to(0);
        run(30);
        // R7: aligned restart at the last bit, no misalignment.
        run_to(F - 1);
        ref_lvl = 1'b1; step(1'b0, 1'b1);
        chk("R7 restart to bit 0", frm_start, 1'b1);
        chk("R9 aligned restart no flag", misalign, 1'b0);
        run(5); ref_lvl = 1'b0; run(20);
        // R7/R9: mid-frame restart sets the flag.
        run_to(13);
        ref_lvl = 1'b1; step(1'b0, 1'b1);
        chk("R7 mid-frame restart", frm_start, 1'b1);
        chk("R9 mid-frame flag", misalign, 1'b1);
        run(8); ref_lvl = 1'b0; run(60);
        clr_lvl = 1'b1; step(1'b0, 1'b0); clr_lvl = 1'b0;
        chk("R9 clear", misalign, 1'b0);
        // R9: set and clear together, set wins.
        step(1'b0, 1'b1);
        run_to(7);
        ref_lvl = 1'b1; clr_lvl = 1'b1; step(1'b0, 1'b1);
        clr_lvl = 1'b0;
        chk("R9 set beats clear", misalign, 1'b1);
        run(4); ref_lvl = 1'b0; clr_lvl = 1'b1; step(1'b0, 1'b0); clr_lvl = 1'b0;
        // Nibble slave: restart at position 21, then groups realign.
        c_nib = 1'b1;
        run_to(0);
        run_to(21);
        ref_lvl = 1'b1; step(1'b0, 1'b1); run(4); ref_lvl = 1'b0;
        run(200);
        // R8: master ignores the reference.
        c_mst = 1'b1; c_nib = 1'b0;
        run_to(0);
        clr_lvl = 1'b1; step(1'b0, 1'b0); clr_lvl = 1'b0;
        run_to(13);
        ref_lvl = 1'b1; step(1'b0, 1'b1);
        chk("R8 master ignores reference", frm_start, 1'b0);
        run(6); ref_lvl = 1'b0; run(100);
        chk("R8 master no flag", misalign, 1'b0);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule